// File: doc/BRIEF.md
# Fractional-Increment System Time Counter

This block is an always-on time base. It advances once per tick of its fixed-frequency clock and publishes a 64-bit count that every consumer in the chip shares. Internally it keeps an 88-bit fixed-point accumulator: 64 integer bits sit above 24 fraction bits, and only the integer part is published. In unscaled operation each tick adds exactly one. In scaled operation each tick adds a programmable 8.24 fixed-point step, so the published count can advance at a rate that is not a whole number.

To cut toggling while consumers sleep, a divisor N can be set. The accumulator then adds N times the per-tick increment once every Nth active tick, and the long-run rate is unchanged. A debug-halt request freezes counting when halting is permitted. The scale mode, step and divisor are captured only while the counter is disabled. A running flag reports that the block is enabled and not halted.

Top module: `systime_counter`

## Requirements
- R1: Reset (synchronous, `rst_n` low) clears the whole accumulator. After reset `count_out` is 0 and `running` is 0.
- R2: With scaling off and an effective divisor of 1, each active tick adds exactly 1 to `count_out`. A tick is active when `run_en` is 1 and not (`halt_allow` is 1 and `halt_req` is 1).
- R3: With scaling on, each active tick adds `step_in`, read as 8.24 fixed point (bits [31:24] integer, bits [23:0] fraction) and aligned to the accumulator fraction. A step of 0x0180_0000 gives counts 0, 1, 3, 4, 6, 7, 9 after 0 to 6 ticks.
- R4: Fraction bits are never published. `count_out` equals floor(accumulator / 2^24), so a sub-unit step advances the count only when the fraction carries.
- R5: With divisor N >= 2 (a divisor of 0 or 1 counts as 1), `count_out` holds for N-1 active ticks and then jumps by N times the per-tick increment. After k*N active ticks it equals the value normal mode gives after k*N ticks.
- R6: While `halt_allow` and `halt_req` are both 1, neither the count nor the position inside a divisor batch advances. `halt_req` alone has no effect.
- R7: `scale_en`, `step_in` and `update_div` are captured on every clock edge where `run_en` is 0. Changes made while `run_en` is 1 have no effect until the counter is disabled again.
- R8: While `run_en` is 0, `count_out` holds its value.
- R9: `running` equals the value of the active condition at the previous clock edge.
- R10: The count is monotonic: a later value is never smaller than an earlier one, except when the 88-bit accumulator wraps modulo 2^88.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fixed-frequency counter clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Counter enable |
| scale_en | input | 1 | Selects the fixed-point step instead of +1 (captured while disabled) |
| step_in | input | 32 | 8.24 step value (captured while disabled) |
| update_div | input | 8 | Batch divisor N (captured while disabled) |
| halt_allow | input | 1 | Permits debug halting |
| halt_req | input | 1 | Debug halt request |
| count_out | output | 64 | Integer part of the accumulator |
| running | output | 1 | Enabled and not halted, registered |

## Verification
The hardest case to reach is a debug halt that lands inside a divisor batch. A frozen phase and a reset phase look the same at the ports until the batch closes. The bench therefore halts after a partial batch, waits out the freeze, and counts exactly how many further active ticks pass before the jump. A full sweep of divisors 0 to 5 against step values gives the fraction carry, the largest step and a zero step a definite expected value on every tick.

// File: rtl/stc_pkg.sv
// Package: shared defaults and helpers for the system time counter.
// Assumes: divisor values 0 and 1 both mean "update every tick".
package stc_pkg;
    localparam int DEF_INT_W      = 64;
    localparam int DEF_FRAC_W     = 24;
    localparam int DEF_STEP_INT_W = 8;
    localparam int DEF_DIV_W      = 8;
endpackage

// File: rtl/stc_cfg_latch.sv
// stc_cfg_latch: holds the scaling mode, step and divisor.
// Assumes: inputs are followed only while the counter is disabled, so a
// running counter never sees a configuration change.
module stc_cfg_latch #(
    parameter int STEP_W = 32,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              scale_in,
    input  logic [STEP_W-1:0] step_in,
    input  logic [DIV_W-1:0]  div_in,
    output logic              scale_q,
    output logic [STEP_W-1:0] step_q,
    output logic [DIV_W-1:0]  div_q
);
    // Capture configuration on every edge where the counter is disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scale_q <= 1'b0;
            step_q  <= '0;
            div_q   <= '0;
        end else if (!run_en) begin
            scale_q <= scale_in;
            step_q  <= step_in;
            div_q   <= div_in;
        end
    end
endmodule

// File: rtl/stc_incr.sv
// stc_incr: forms the amount added on each accumulator update.
// Assumes: the step is fixed point with FRAC_W fraction bits that line up
// with the accumulator fraction; the batch is the per-tick increment times
// the effective divisor.
module stc_incr #(
    parameter int INT_W  = 64,
    parameter int FRAC_W = 24,
    parameter int STEP_W = 32,
    parameter int DIV_W  = 8
) (
    input  logic                    scale,
    input  logic [STEP_W-1:0]       step,
    input  logic [DIV_W-1:0]        div,
    output logic [DIV_W-1:0]        n_eff,
    output logic [INT_W+FRAC_W-1:0] batch
);
    localparam int ACC_W = INT_W + FRAC_W;

    logic [ACC_W-1:0] step_wide;
    logic [ACC_W-1:0] unit;

    // Zero-extend the step to the accumulator width when it is narrower.
    generate
        if (STEP_W < ACC_W) begin : g_ext
            assign step_wide = {{(ACC_W-STEP_W){1'b0}}, step};
        end else begin : g_trunc
            assign step_wide = step[ACC_W-1:0];
        end
    endgenerate

    // Divisors 0 and 1 both mean one update per tick.
    always_comb begin
        n_eff = (div <= DIV_W'(1)) ? DIV_W'(1) : div;
    end

    // Per-tick increment: the step when scaling, else one integer unit.
    always_comb begin
        unit = scale ? step_wide : (ACC_W'(1) << FRAC_W);
    end

    // Batch increment applied once every n_eff active ticks.
    always_comb begin
        batch = unit * ACC_W'(n_eff);
    end
endmodule

// File: rtl/stc_pacer.sv
// stc_pacer: counts active ticks and marks the last tick of each batch.
// Assumes: the phase restarts while disabled and freezes while halted.
module stc_pacer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             active,
    input  logic [DIV_W-1:0] n_eff,
    output logic             fire,
    output logic [DIV_W-1:0] phase_q
);
    logic last;

    // The batch closes when the phase reaches n_eff - 1.
    always_comb begin
        last = (phase_q == (n_eff - DIV_W'(1)));
        fire = active && last;
    end

    // Advance the phase on active ticks and clear it while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (!run_en) begin
            phase_q <= '0;
        end else if (active) begin
            phase_q <= last ? '0 : phase_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/stc_accum.sv
// stc_accum: the fixed-point time accumulator.
// Assumes: wraps modulo 2^ACC_W; adds the batch only on a fire tick.
module stc_accum #(
    parameter int ACC_W = 88
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic [ACC_W-1:0] batch,
    output logic [ACC_W-1:0] acc_q
);
    // Add the batch increment on each batch boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (fire) begin
            acc_q <= acc_q + batch;
        end
    end
endmodule

// File: rtl/systime_counter.sv
// systime_counter: always-on system time base with fractional stepping.
// Assumes: a fixed-frequency clock; configuration is changed only while
// disabled; consumers read the integer part of the accumulator.
module systime_counter #(
    parameter int INT_W      = stc_pkg::DEF_INT_W,
    parameter int FRAC_W     = stc_pkg::DEF_FRAC_W,
    parameter int STEP_INT_W = stc_pkg::DEF_STEP_INT_W,
    parameter int DIV_W      = stc_pkg::DEF_DIV_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         run_en,
    input  logic                         scale_en,
    input  logic [STEP_INT_W+FRAC_W-1:0] step_in,
    input  logic [DIV_W-1:0]             update_div,
    input  logic                         halt_allow,
    input  logic                         halt_req,
    output logic [INT_W-1:0]             count_out,
    output logic                         running
);
    localparam int STEP_W = STEP_INT_W + FRAC_W;
    localparam int ACC_W  = INT_W + FRAC_W;

    logic              scale_q;
    logic [STEP_W-1:0] step_q;
    logic [DIV_W-1:0]  div_q;
    logic [DIV_W-1:0]  n_eff;
    logic [ACC_W-1:0]  batch;
    logic [ACC_W-1:0]  acc_q;
    logic [DIV_W-1:0]  phase_q;
    logic              fire;
    logic              active;

    // A tick counts when enabled and not held by a permitted debug halt.
    always_comb begin
        active = run_en && !(halt_allow && halt_req);
    end

    stc_cfg_latch #(.STEP_W(STEP_W), .DIV_W(DIV_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .run_en(run_en),
        .scale_in(scale_en), .step_in(step_in), .div_in(update_div),
        .scale_q(scale_q), .step_q(step_q), .div_q(div_q)
    );

    stc_incr #(.INT_W(INT_W), .FRAC_W(FRAC_W), .STEP_W(STEP_W), .DIV_W(DIV_W)) u_incr (
        .scale(scale_q), .step(step_q), .div(div_q),
        .n_eff(n_eff), .batch(batch)
    );

    stc_pacer #(.DIV_W(DIV_W)) u_pacer (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .active(active),
        .n_eff(n_eff), .fire(fire), .phase_q(phase_q)
    );

    stc_accum #(.ACC_W(ACC_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .fire(fire), .batch(batch), .acc_q(acc_q)
    );

    // Publish only the integer part of the accumulator.
    always_comb begin
        count_out = acc_q[ACC_W-1 -: INT_W];
    end

    // Register the running status one edge after enable or halt change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
        end else begin
            running <= active;
        end
    end
endmodule

// File: rtl/stc_checker.sv
// stc_checker: temporal properties of the system time counter, bound to
// the top module. Assumes a synchronous active-low reset.
module stc_checker #(
    parameter int INT_W  = 64,
    parameter int STEP_W = 32,
    parameter int DIV_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run_en,
    input logic              halt_allow,
    input logic              halt_req,
    input logic              running,
    input logic [INT_W-1:0]  count_out,
    input logic              cfg_scale,
    input logic [STEP_W-1:0] cfg_step,
    input logic [DIV_W-1:0]  cfg_div,
    input logic [DIV_W-1:0]  n_eff,
    input logic [DIV_W-1:0]  phase_q
);
    logic armed;
    logic tick_ok;

    // Arm the checks one edge after reset has been released.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // Port-level view of an active tick.
    always_comb begin
        tick_ok = run_en && !(halt_allow && halt_req);
    end

    // R8
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        !$past(tick_ok) |-> $stable(count_out));

    // R9
    running_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        running == $past(tick_ok));

    // R2
    unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ($past(tick_ok) && !$past(cfg_scale) && $past(n_eff) == DIV_W'(1))
        |-> count_out == $past(count_out) + INT_W'(1));

    // R5
    mid_batch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ($past(phase_q) != $past(n_eff) - DIV_W'(1)) |-> $stable(count_out));

    // R7
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(run_en) |-> ($stable(cfg_scale) && $stable(cfg_step) && $stable(cfg_div)));

    // R10
    monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (count_out >= $past(count_out)) || ($past(count_out) > {{(INT_W-16){1'b1}}, 16'h0000}));
endmodule

bind systime_counter stc_checker #(.INT_W(INT_W), .STEP_W(STEP_W), .DIV_W(DIV_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .halt_allow(halt_allow),
    .halt_req(halt_req), .running(running), .count_out(count_out),
    .cfg_scale(scale_q), .cfg_step(step_q), .cfg_div(div_q),
    .n_eff(n_eff), .phase_q(phase_q)
);

// File: tb/tb_systime_counter.sv
module tb_systime_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic        scale_en = 1'b0;
    logic [31:0] step_in = '0;
    logic [7:0]  update_div = '0;
    logic        halt_allow = 1'b0;
    logic        halt_req = 1'b0;
    logic [63:0] count_out;
    logic        running;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    systime_counter dut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .scale_en(scale_en),
        .step_in(step_in), .update_div(update_div), .halt_allow(halt_allow),
        .halt_req(halt_req), .count_out(count_out), .running(running)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // Reset, load configuration while disabled, leave the counter disabled.
    task automatic restart(input logic sc, input logic [31:0] st, input logic [7:0] dv);
        @(negedge clk);
        rst_n = 1'b0; run_en = 1'b0; halt_allow = 1'b0; halt_req = 1'b0;
        scale_en = sc; step_in = st; update_div = dv;
        tick(1);
        rst_n = 1'b1;
        tick(1);
    endtask

    function automatic logic [63:0] model(input logic sc, input logic [31:0] st,
                                          input logic [7:0] dv, input int k);
        logic [87:0] inc;
        logic [87:0] acc;
        int n;
        n = (dv <= 8'd1) ? 1 : int'(dv);
        inc = sc ? 88'(st) : (88'd1 << 24);
        acc = 88'(k / n) * 88'(n) * inc;
        return acc[87:24];
    endfunction

    initial begin
        logic [31:0] steps [7];
        steps = '{32'h0180_0000, 32'h0040_0000, 32'h0000_0001, 32'hFFFF_FFFF,
                  32'h0100_0000, 32'h0000_0000, 32'h0AAA_AAAB};

        // R1: reset state
        restart(1'b0, 32'h0, 8'd0);
        check("R1 count after reset", count_out, 64'd0);
        check("R1 running after reset", 64'(running), 64'd0);

        // R3: documented 1.5 step sequence
        restart(1'b1, 32'h0180_0000, 8'd1);
        run_en = 1'b1;
        begin
            logic [63:0] seq [7];
            seq = '{64'd0, 64'd1, 64'd3, 64'd4, 64'd6, 64'd7, 64'd9};
            check("R3 tick0", count_out, seq[0]);
            for (int k = 1; k < 7; k++) begin
                tick(1);
                check("R3 step 1.5 sequence", count_out, seq[k]);
            end
        end
        check("R9 running while enabled", 64'(running), 64'd1);

        // R2 R4 R5: sweep over scale mode, step and divisor
        for (int dv = 0; dv < 6; dv++) begin
            for (int s = -1; s < 7; s++) begin
                logic sc;
                logic [31:0] st;
                sc = (s >= 0);
                st = (s >= 0) ? steps[s] : 32'h1234_5678;
                restart(sc, st, 8'(dv));
                run_en = 1'b1;
                for (int k = 1; k <= 24; k++) begin
                    tick(1);
                    if (!sc)
                        check("R2/R5 unscaled sweep", count_out, model(sc, st, 8'(dv), k));
                    else if (dv > 1)
                        check("R5 batch sweep", count_out, model(sc, st, 8'(dv), k));
                    else
                        check("R3/R4 scaled sweep", count_out, model(sc, st, 8'(dv), k));
                end
            end
        end

        // R6: halt freezes count and status; halt_req alone is ignored
        restart(1'b0, 32'h0, 8'd1);
        run_en = 1'b1;
        tick(5);
        check("R6 before halt", count_out, 64'd5);
        halt_allow = 1'b1; halt_req = 1'b1;
        tick(1);
        check("R9 running drops on halt", 64'(running), 64'd0);
        tick(3);
        check("R6 count frozen in halt", count_out, 64'd5);
        halt_allow = 1'b0;
        tick(2);
        check("R6 halt_req alone ignored", count_out, 64'd7);
        check("R9 running with ignored halt", 64'(running), 64'd1);

        // R6 R5: halt inside a batch keeps the phase
        restart(1'b0, 32'h0, 8'd3);
        run_en = 1'b1;
        tick(2);
        check("R5 mid batch hold", count_out, 64'd0);
        halt_allow = 1'b1; halt_req = 1'b1;
        tick(3);
        check("R6 frozen mid batch", count_out, 64'd0);
        halt_req = 1'b0;
        tick(1);
        check("R6 phase kept over halt", count_out, 64'd3);

        // R7 R8: configuration changes while running are ignored
        restart(1'b0, 32'h0, 8'd1);
        run_en = 1'b1;
        tick(3);
        scale_en = 1'b1; step_in = 32'h0500_0000; update_div = 8'd4;
        tick(3);
        check("R7 running ignores new config", count_out, 64'd6);
        run_en = 1'b0;
        tick(2);
        check("R8 hold while disabled", count_out, 64'd6);
        check("R9 running low while disabled", 64'(running), 64'd0);
        run_en = 1'b1;
        tick(3);
        check("R7 new config mid batch", count_out, 64'd6);
        tick(1);
        check("R7 new config after re-enable", count_out, 64'd26);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule